// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is an I2C target that sits in front of a byte-wide memory with a 17-bit address space. It answers a 7-bit device address. That address is made of a fixed 4-bit prefix, two chip-select bits taken from strap pins, and address bit 16 of the memory. A write transfer carries two address bytes after the header, the high byte first. Any data bytes that follow go to consecutive locations. If a repeated START comes straight after the address bytes, the transfer ends without a write and the internal pointer keeps the received address. A read header then streams bytes from that pointer for as long as the master acknowledges them. The pointer wraps from the top location to zero. A high-speed master code is left unanswered, and the target waits for the repeated START that follows it.

SCL and SDA each pass through a synchroniser before edge detection. START and STOP are seen as an SDA edge while SCL is high. The target pulls SDA low through an open-drain enable. The memory port is synchronous: a write strobe with its data, and a read strobe whose data returns one cycle later.

The controller states are IDLE, HDR (header byte), HDR_ACK, AHI (high address byte), AHI_ACK, ALO (low address byte), ALO_ACK, WR (data byte in), WR_ACK, RD (data byte out), RD_ACK (master acknowledge), HS_WAIT and IGNORE. The transitions are as follows:

- START moves to HDR from any state. STOP moves to IDLE from any state.
- HDR goes to HDR_ACK when the header matches, to HS_WAIT on a master code, and to IGNORE otherwise.
- Each receive state (HDR, AHI, ALO, WR) moves to its acknowledge state on the eighth bit.
- An acknowledge state moves on at the falling SCL edge that ends the acknowledge bit:
  - HDR_ACK goes to AHI after a write header, or to RD after a read header.
  - AHI_ACK goes to ALO.
  - ALO_ACK goes to WR.
  - WR_ACK goes back to WR.
- RD moves to RD_ACK on the eighth bit.
- From RD_ACK, an ACK from the master leads back to RD, and a NACK leads to IGNORE.

Top module: `i2c_mem_target`

## Requirements
- R1: A header byte is acknowledged only if bits 7..4 equal 1010 and bits 3..2 equal chip_sel[1:0]. After any other header the target never pulls SDA low and writes nothing until the next START or STOP.
- R2: In a write header, bit 1 is address bit 16 and bit 0 is 0. The two bytes that follow give address bits 15..8 and then bits 7..0, and the target acknowledges each of them.
- R3: A repeated START right after the acknowledged low address byte writes nothing and leaves the pointer at the 17-bit address received. The next read header (bit 0 = 1) ignores its bit 1 and starts at that pointer.
- R4: During a read, the target presents data MSB first. Each ACK from the master (SDA low on the ninth rising edge) leads to the byte at the next address. A NACK releases SDA until the next START or STOP.
- R5: The pointer advances after each byte transferred, and it wraps from 0x1FFFF to 0x00000 for both reads and writes.
- R6: Each data byte after the address bytes in a write is acknowledged and stored at the pointer, and the pointer then advances.
- R7: A byte of the form 0000_1xxx after START is not acknowledged. A following repeated START with a valid header is served normally.
- R8: The target changes its SDA pull-down only while SCL is low, except when it releases SDA.
- R9: A START or STOP in the middle of a byte drops the partial byte and no write takes place. START returns to header reception and releases SDA.
- R10: After reset, SDA is released and neither memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| chip_sel | input | 2 | Strap bits compared with header bits 3..2 |
| mem_addr | output | 17 | Memory address (the pointer) |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe, one cycle |
| mem_re | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_rdata | input | 8 | Read data |

## Verification
The bench builds the block with its defaults: prefix 1010, two synchroniser stages and the full 17-bit pointer, with chip_sel strapped to 10. Because address bit 16 travels in the header, the top location 0x1FFFF can be reached in a single write header. That lets both the read wrap and the write wrap to zero be tested directly. The bench also sets address bit 16 differently in the following read header, which shows that the read header ignores that bit.

// File: rtl/smt_pkg.sv
package smt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 1 + 2 * BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR, ST_HDR_ACK, ST_AHI, ST_AHI_ACK, ST_ALO, ST_ALO_ACK,
        ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_HS_WAIT, ST_IGNORE
    } st_e;
endpackage

// File: rtl/smt_sync.sv
module smt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic scl_q, sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= scl_i;
                    sda_p <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= {scl_p[STAGES-2:0], scl_i};
                    sda_p <= {sda_p[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;
    assign bus_start = scl_s && scl_q && sda_q && !sda_s;
    assign bus_stop  = scl_s && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/smt_addr_ctr.sv
module smt_addr_ctr import smt_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= load_val;
        else if (inc)  addr <= addr + 1'b1;
    end
endmodule

// File: rtl/smt_fsm.sv
module smt_fsm import smt_pkg::*; #(
    parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [1:0]        chip_sel,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              ctr_load,
    output logic [ADDR_W-1:0] ctr_val,
    output logic              ctr_inc,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    st_e state, state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, addr_hi, wd_q, byte_in;
    logic half, hdr_rd, hdr_msb, oe_q, we_q, rd_req, rd_cap;
    logic last_bit, is_me, is_mcode, bus_evt;

    assign byte_in  = {rx_sh[BYTE_W-2:0], sda_s};
    assign last_bit = scl_rise && (bit_cnt == LAST);
    assign is_me    = (byte_in[7:4] == DEV_PREFIX) && (byte_in[3:2] == chip_sel);
    assign is_mcode = (byte_in[7:3] == 5'b00001);
    assign bus_evt  = bus_start || bus_stop;

    always_comb begin
        state_n = state;
        if (bus_stop)       state_n = ST_IDLE;
        else if (bus_start) state_n = ST_HDR;
        else begin
            unique case (state)
                ST_HDR:     if (last_bit) state_n = is_me ? ST_HDR_ACK :
                                                   (is_mcode ? ST_HS_WAIT : ST_IGNORE);
                ST_AHI:     if (last_bit) state_n = ST_AHI_ACK;
                ST_ALO:     if (last_bit) state_n = ST_ALO_ACK;
                ST_WR:      if (last_bit) state_n = ST_WR_ACK;
                ST_RD:      if (last_bit) state_n = ST_RD_ACK;
                ST_HDR_ACK: if (scl_fall && half) state_n = hdr_rd ? ST_RD : ST_AHI;
                ST_AHI_ACK: if (scl_fall && half) state_n = ST_ALO;
                ST_ALO_ACK: if (scl_fall && half) state_n = ST_WR;
                ST_WR_ACK:  if (scl_fall && half) state_n = ST_WR;
                ST_RD_ACK: begin
                    if (scl_rise && half && sda_s) state_n = ST_IGNORE;
                    else if (scl_fall && half)     state_n = ST_RD;
                end
                default:    state_n = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;  rx_sh <= '0;  tx_sh <= '0;  addr_hi <= '0;  wd_q <= '0;
            half <= 1'b0;   hdr_rd <= 1'b0;  hdr_msb <= 1'b0;  oe_q <= 1'b0;
            we_q <= 1'b0;   rd_req <= 1'b0;  rd_cap <= 1'b0;
        end else begin
            we_q   <= 1'b0;
            rd_req <= 1'b0;
            rd_cap <= rd_req;
            if (bus_evt) begin
                bit_cnt <= '0;
                half    <= 1'b0;
                oe_q    <= 1'b0;
            end else begin
                case (state)
                    ST_HDR, ST_AHI, ST_ALO, ST_WR: begin
                        if (scl_rise) begin
                            rx_sh   <= byte_in;
                            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                        end
                        if (last_bit) begin
                            if (state == ST_HDR && is_me) begin
                                hdr_rd <= byte_in[0];
                                rd_req <= byte_in[0];
                                if (!byte_in[0]) hdr_msb <= byte_in[1];
                            end
                            if (state == ST_AHI) addr_hi <= byte_in;
                            if (state == ST_WR) begin
                                we_q <= 1'b1;
                                wd_q <= byte_in;
                            end
                        end
                    end
                    ST_HDR_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            half <= !half;
                            if (!half) oe_q <= 1'b1;
                            else begin
                                bit_cnt <= '0;
                                oe_q    <= (state == ST_HDR_ACK && hdr_rd) ? !tx_sh[BYTE_W-1] : 1'b0;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                        if (scl_fall && bit_cnt != '0) begin
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                            oe_q  <= !tx_sh[BYTE_W-2];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_fall) begin
                            half <= !half;
                            oe_q <= half ? !tx_sh[BYTE_W-1] : 1'b0;
                            if (half) bit_cnt <= '0;
                        end
                        if (scl_rise && half && !sda_s) rd_req <= 1'b1;
                    end
                    default: oe_q <= 1'b0;
                endcase
            end
            if (rd_cap) tx_sh <= mem_rdata;
        end
    end

    assign ctr_load  = !bus_evt && (state == ST_ALO) && last_bit;
    assign ctr_val   = {hdr_msb, addr_hi, byte_in};
    assign ctr_inc   = we_q || (!bus_evt && state == ST_RD_ACK && scl_rise && half);
    assign sda_oe    = oe_q;
    assign mem_we    = we_q;
    assign mem_wdata = wd_q;
    assign mem_re    = rd_req;

    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(oe_q) && oe_q) |-> !scl_s);
    // R7
    mcode_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HS_WAIT) |-> !oe_q);
    // R6
    write_in_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> (state == ST_WR_ACK));
    // R5
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> (cur_addr == $past(cur_addr) + 1'b1));
    // R9
    start_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (state == ST_HDR) && !oe_q);
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target import smt_pkg::*; #(
    parameter logic [3:0] DEV_PREFIX  = 4'b1010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        chip_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata
);
    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic ctr_load, ctr_inc;
    logic [ADDR_W-1:0] ctr_val;

    smt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    smt_addr_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(ctr_val),
        .inc(ctr_inc), .addr(mem_addr)
    );

    smt_fsm #(.DEV_PREFIX(DEV_PREFIX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
        .bus_stop(bus_stop), .chip_sel(chip_sel), .cur_addr(mem_addr),
        .ctr_load(ctr_load), .ctr_val(ctr_val), .ctr_inc(ctr_inc),
        .sda_oe(sda_oe), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );
endmodule

// File: tb/sim_i2c_mem_target.sv
`timescale 1ns/1ps
module sim_i2c_mem_target;
    localparam int QC = 10;
    localparam int AMASK = 32'h1FFFF;
    localparam logic [1:0] STRAP = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic sda_oe, mem_we, mem_re;
    logic [16:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int viol = 0;
    int exp_ptr = 0;
    bit done = 0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;
    logic [7:0] dut_mem [int];
    logic [7:0] exp_mem [int];

    always #2 clk = !clk;
    assign sda_line = msda & !sda_oe;

    i2c_mem_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .chip_sel(STRAP), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) ^ (a >> 9));
    endfunction

    function automatic logic [7:0] exp_read(int a);
        return exp_mem.exists(a) ? exp_mem[a] : pat(a);
    endfunction

    always @(posedge clk) begin
        if (mem_we) dut_mem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= dut_mem.exists(int'(mem_addr)) ? dut_mem[int'(mem_addr)]
                                                                : pat(int'(mem_addr));
    end

    always @(negedge clk) begin
        if (rst_n && scl && prev_scl && (sda_oe !== prev_oe)) viol++;
        prev_scl <= scl;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic tick();
        repeat (QC) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        msda = 1'b1; tick(); scl = 1'b1; tick(); msda = 1'b0; tick(); scl = 1'b0; tick();
    endtask

    task automatic bus_stop();
        msda = 1'b0; tick(); scl = 1'b1; tick(); msda = 1'b1; tick();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            msda = b[i]; tick(); scl = 1'b1; tick(); tick(); scl = 1'b0; tick();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        msda = 1'b1; tick(); scl = 1'b1; tick();
        acked = !sda_line;
        tick(); scl = 1'b0; tick();
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        msda = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            scl = 1'b1; tick(); b = {b[6:0], sda_line}; tick(); scl = 1'b0; tick();
        end
        msda = !ack; tick(); scl = 1'b1; tick(); tick(); scl = 1'b0; tick();
        msda = 1'b1;
    endtask

    task automatic addr_phase(input int addr);
        logic a;
        bus_start();
        send_byte({4'b1010, STRAP, addr[16], 1'b0}, a);
        chk(a, "R1 header ack", int'(a), 1);
        send_byte(addr[15:8], a);
        chk(a, "R2 high address ack", int'(a), 1);
        send_byte(addr[7:0], a);
        chk(a, "R2 low address ack", int'(a), 1);
        exp_ptr = addr & AMASK;
    endtask

    task automatic write_txn(input int addr, input logic [7:0] d [$]);
        logic a;
        addr_phase(addr);
        foreach (d[i]) begin
            send_byte(d[i], a);
            chk(a, "R6 data ack", int'(a), 1);
            exp_mem[exp_ptr] = d[i];
            exp_ptr = (exp_ptr + 1) & AMASK;
        end
        bus_stop();
    endtask

    task automatic read_body(input int n, input logic a16_rd, input string tag);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte({4'b1010, STRAP, a16_rd, 1'b1}, a);
        chk(a, "R3 read header ack", int'(a), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk(b == exp_read(exp_ptr), tag, int'(b), int'(exp_read(exp_ptr)));
            exp_ptr = (exp_ptr + 1) & AMASK;
        end
        bus_stop();
    endtask

    task automatic read_txn(input int addr, input int n, input logic a16_rd, input string tag);
        addr_phase(addr);
        read_body(n, a16_rd, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] b;
        int mism;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R10 reset state
        chk(sda_oe == 1'b0, "R10 sda_oe", int'(sda_oe), 0);
        chk(mem_we == 1'b0 && mem_re == 1'b0, "R10 strobes", int'({mem_we, mem_re}), 0);

        // R2 R6 plain write of three bytes
        write_txn(32'h01234, '{8'hA1, 8'hB2, 8'hC3});
        // R3 R4 random read with sequential continuation
        read_txn(32'h01234, 3, 1'b1, "R4 sequential read data");

        // R1 wrong chip select: nothing acknowledged, nothing written
        bus_start();
        send_byte({4'b1010, 2'b01, 1'b0, 1'b0}, a);
        chk(!a, "R1 wrong strap nack", int'(a), 0);
        send_byte(8'h12, a);
        chk(!a, "R1 ignored byte nack", int'(a), 0);
        send_byte(8'h34, a);
        send_byte(8'h99, a);
        chk(!a, "R1 ignored data nack", int'(a), 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0, 1'b0}, a);
        chk(!a, "R1 wrong prefix nack", int'(a), 0);
        bus_stop();
        read_txn(32'h01234, 1, 1'b0, "R1 memory untouched");

        // R5 read wrap, read header bit1 differs from stored A16 (R3)
        read_txn(32'h1FFFF, 3, 1'b0, "R5 read wrap");
        // R5 write wrap
        write_txn(32'h1FFFF, '{8'h77, 8'h88});
        read_txn(32'h1FFFF, 2, 1'b1, "R5 write wrap readback");

        // R7 master code then repeated START and a valid write
        bus_start();
        send_byte(8'h0B, a);
        chk(!a, "R7 master code nack", int'(a), 0);
        write_txn(32'h00400, '{8'h5E});
        read_txn(32'h00400, 1, 1'b0, "R7 write after master code");

        // R9 repeated START inside a data byte: no write, pointer kept
        addr_phase(32'h00200);
        send_bits(8'h99, 4);
        read_body(1, 1'b1, "R9 partial byte dropped");

        // R6 R9 whole memory image matches the model
        mism = 0;
        foreach (exp_mem[k]) if (!dut_mem.exists(k) || dut_mem[k] !== exp_mem[k]) mism++;
        chk(mism == 0 && dut_mem.num() == exp_mem.num(), "R9 memory image",
            dut_mem.num(), exp_mem.num());
        // R8 per-clock monitor
        chk(viol == 0, "R8 SDA change while SCL high", viol, 0);
        finish_run();
    end
endmodule